// File: doc/BRIEF.md
# Configurable Trigger Decision Unit

This block turns a wide set of synchronous detector summary words into one accept/reject verdict per bunch crossing. On every clock it captures 24 words of 32 bits, pulls a bit field out of a chosen word for each of 16 elementary condition slots, and tests that field against a per-slot threshold with greater, less or equal. A field may be added to the field of the next slot before the test, so that quantities such as energy sums can be cut on. The same source field may feed several slots with different thresholds at once.

Eight trigger conditions each AND together the slots their masks select. The decision is the OR of the trigger conditions. The decision and the trigger bits go out together as a 16-bit word for a downstream supervisor. Each input word first passes a per-word delay of 0 to 7 cycles, so that sources with different latencies line up on the same crossing.

All selections, thresholds, masks and delays are written through a simple register port into a shadow copy. A single apply strobe moves the whole shadow into the working set, so that no crossing is ever judged against a half-written setup.

Top module: `trig_decision_unit`

## Requirements
- R1: After reset the working setup has every slot disabled (operator 11), every mask zero and every delay zero, so `decision` is 0 and `sup_word` is 0x0000.
- R2: A slot with operator 00 is true when its value is strictly greater than its 16-bit threshold.
- R3: A slot with operator 01 is true when its value is strictly less than its threshold.
- R4: A slot with operator 10 is true when its value equals its threshold.
- R5: A slot with operator 11 is always false, whatever its data.
- R6: When slot bit 24 is set, the slot's value is its own field plus the field of slot (n+1) mod 16, as an unsigned 13-bit sum.
- R7: Several slots reading the same field compare against their own thresholds independently in the same cycle.
- R8: Trigger condition k (mask at address 32+k) is true when its 16-bit mask is non-zero and every slot selected by the mask is true; an all-zero mask never fires.
- R9: `decision` is the OR of the eight trigger conditions; `sup_word` carries the trigger conditions in bits 7:0, the decision in bit 8 and zeros in bits 15:9.
- R10: With the delay of word w (address 64+w, bits 2:0) set to d, a word captured at clock edge t drives the outputs visible after edge t+d+3.
- R11: Register writes land in the shadow copy only; the working setup changes only at an edge where `cfg_apply` is high, and then takes the shadow contents present before any write at that same edge.
- R12: A slot (address n, 0..15) selects word index in bits 4:0, right-shift offset in bits 9:5 and 12-bit field mask in bits 21:10, operator in bits 23:22; thresholds sit at address 16+n; an index of 24 or more reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_words | input | 768 | 24 input words, word w at bits 32w+31:32w |
| cfg_we | input | 1 | Shadow register write enable |
| cfg_addr | input | 7 | Shadow register address |
| cfg_wdata | input | 32 | Shadow register write data |
| cfg_apply | input | 1 | Copy the whole shadow setup into the working setup |
| decision | output | 1 | Accept verdict for the crossing |
| sup_word | output | 16 | Word for the supervisor: triggers, decision, reserved zeros |

## Verification
A word captured at edge t reaches the delay stage output after edge t+d, the slot results one edge later, the trigger bits one edge after that and both outputs after edge t+d+3; the bench model keeps its own history of the last eight input sets and a three-deep queue of expected output words, so every comparison made at the falling edge targets exactly that cycle. An apply strobe changes the setup under crossings already in flight, so the per-cycle comparison pauses for the four cycles after an apply and resumes once the pipeline holds only crossings judged against the new setup. Directed checks hold the inputs steady long enough to settle, then read the outputs, and the delay check pulses one word for a single cycle and samples the edges just before, at and after the expected one.

// File: rtl/tdu_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes, register layout and slot record for the trigger
// decision unit. Assumes the address map fits in ADDR_W bits.
package tdu_pkg;
    localparam int N_WORDS = 24;
    localparam int WORD_W  = 32;
    localparam int N_SLOT  = 16;
    localparam int N_TRIG  = 8;
    localparam int THR_W   = 16;
    localparam int FLD_W   = 12;
    localparam int SEL_W   = 5;
    localparam int OFF_W   = 5;
    localparam int DLY_W   = 3;
    localparam int OUT_W   = 16;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 32;
    localparam int MAX_DLY = (1 << DLY_W) - 1;
    localparam int A_SLOT  = 0;
    localparam int A_THR   = A_SLOT + N_SLOT;
    localparam int A_MASK  = A_THR + N_SLOT;
    localparam int A_DLY   = 64;

    typedef enum logic [1:0] {
        OP_GT  = 2'b00,
        OP_LT  = 2'b01,
        OP_EQ  = 2'b10,
        OP_OFF = 2'b11
    } op_e;

    typedef struct packed {
        logic             sum_en;
        op_e              op;
        logic [FLD_W-1:0] fmask;
        logic [OFF_W-1:0] off;
        logic [SEL_W-1:0] idx;
    } slot_t;

    localparam int    SLOT_W   = $bits(slot_t);
    localparam slot_t SLOT_RST = '{sum_en: 1'b0, op: OP_OFF, fmask: '0, off: '0, idx: '0};
endpackage

// File: rtl/tdu_cfg.sv
`timescale 1ns/1ps
// Module: shadow and working copies of the whole setup. Writes go to the
// shadow; cfg_apply copies the shadow (as it stood before this edge's write)
// into the working set. Assumes one write per cycle.
module tdu_cfg
    import tdu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic                cfg_apply,
    output slot_t               act_slot [N_SLOT],
    output logic [THR_W-1:0]    act_thr  [N_SLOT],
    output logic [N_SLOT-1:0]   act_mask [N_TRIG],
    output logic [DLY_W-1:0]    act_dly  [N_WORDS]
);
    slot_t               sh_slot [N_SLOT];
    logic [THR_W-1:0]    sh_thr  [N_SLOT];
    logic [N_SLOT-1:0]   sh_mask [N_TRIG];
    logic [DLY_W-1:0]    sh_dly  [N_WORDS];

    // Purpose: decode a register write into the shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOT; i++) begin
                sh_slot[i] <= SLOT_RST;
                sh_thr[i]  <= '0;
            end
            for (int k = 0; k < N_TRIG; k++) sh_mask[k] <= '0;
            for (int w = 0; w < N_WORDS; w++) sh_dly[w] <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < N_SLOT; i++) begin
                if (cfg_addr == ADDR_W'(A_SLOT + i)) sh_slot[i] <= slot_t'(cfg_wdata[SLOT_W-1:0]);
                if (cfg_addr == ADDR_W'(A_THR + i))  sh_thr[i]  <= cfg_wdata[THR_W-1:0];
            end
            for (int k = 0; k < N_TRIG; k++)
                if (cfg_addr == ADDR_W'(A_MASK + k)) sh_mask[k] <= cfg_wdata[N_SLOT-1:0];
            for (int w = 0; w < N_WORDS; w++)
                if (cfg_addr == ADDR_W'(A_DLY + w)) sh_dly[w] <= cfg_wdata[DLY_W-1:0];
        end
    end

    // Purpose: move the complete shadow setup into the working set on apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOT; i++) begin
                act_slot[i] <= SLOT_RST;
                act_thr[i]  <= '0;
            end
            for (int k = 0; k < N_TRIG; k++) act_mask[k] <= '0;
            for (int w = 0; w < N_WORDS; w++) act_dly[w] <= '0;
        end else if (cfg_apply) begin
            act_slot <= sh_slot;
            act_thr  <= sh_thr;
            act_mask <= sh_mask;
            act_dly  <= sh_dly;
        end
    end
endmodule

// File: rtl/tdu_align.sv
`timescale 1ns/1ps
// Module: per-word latency alignment. Each word runs through a MAX_DLY-deep
// shift history; the registered output taps it at the word's delay, so a word
// captured at edge t appears after edge t+d. Assumes delays change only on apply.
module tdu_align
    import tdu_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_WORDS*WORD_W-1:0]  in_flat,
    input  logic [DLY_W-1:0]           dly     [N_WORDS],
    output logic [WORD_W-1:0]          aligned [N_WORDS]
);
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] hist [1:MAX_DLY];
        logic [WORD_W-1:0] taps [0:MAX_DLY];

        assign taps[0] = in_flat[w*WORD_W +: WORD_W];
        for (genvar k = 1; k <= MAX_DLY; k++) begin : g_tap
            assign taps[k] = hist[k];
        end

        // Purpose: shift the word history and register the selected tap.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 1; k <= MAX_DLY; k++) hist[k] <= '0;
                aligned[w] <= '0;
            end else begin
                hist[1] <= taps[0];
                for (int k = 2; k <= MAX_DLY; k++) hist[k] <= hist[k-1];
                aligned[w] <= taps[dly[w]];
            end
        end
    end
endmodule

// File: rtl/tdu_elem.sv
`timescale 1ns/1ps
// Module: elementary condition slots. Each slot extracts a masked, shifted
// field from its selected word, optionally adds the next slot's field, and
// compares against its threshold. One register stage. Assumes an index at or
// beyond N_WORDS means a zero source.
module tdu_elem
    import tdu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  aligned  [N_WORDS],
    input  slot_t              act_slot [N_SLOT],
    input  logic [THR_W-1:0]   act_thr  [N_SLOT],
    output logic [N_SLOT-1:0]  elem_q
);
    logic [FLD_W-1:0] fld [N_SLOT];

    for (genvar s = 0; s < N_SLOT; s++) begin : g_fld
        logic [WORD_W-1:0] src;
        // Purpose: select the source word and cut out the slot's field.
        always_comb begin
            src = (int'(act_slot[s].idx) < N_WORDS) ? aligned[act_slot[s].idx] : '0;
            fld[s] = FLD_W'(src >> act_slot[s].off) & act_slot[s].fmask;
        end
    end

    for (genvar s = 0; s < N_SLOT; s++) begin : g_cmp
        localparam int NXT = (s + 1) % N_SLOT;
        logic [THR_W-1:0] val;
        logic             hit;
        // Purpose: form the slot value and apply the selected operator.
        always_comb begin
            val = act_slot[s].sum_en ? THR_W'({1'b0, fld[s]} + {1'b0, fld[NXT]})
                                     : THR_W'(fld[s]);
            unique case (act_slot[s].op)
                OP_GT:   hit = (val >  act_thr[s]);
                OP_LT:   hit = (val <  act_thr[s]);
                OP_EQ:   hit = (val == act_thr[s]);
                default: hit = 1'b0;
            endcase
        end
        // Purpose: register the slot result.
        always_ff @(posedge clk) begin
            if (!rst_n) elem_q[s] <= 1'b0;
            else        elem_q[s] <= hit;
        end
    end
endmodule

// File: rtl/tdu_comb.sv
`timescale 1ns/1ps
// Module: trigger condition network and output word. Each condition ANDs the
// slots its mask selects (empty mask never fires); the decision ORs them.
// Two register stages. Assumes OUT_W > N_TRIG.
module tdu_comb
    import tdu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOT-1:0]  elem_q,
    input  logic [N_SLOT-1:0]  act_mask [N_TRIG],
    output logic [N_TRIG-1:0]  trig_q,
    output logic               dec_q,
    output logic [OUT_W-1:0]   sup_q
);
    localparam int PAD_W = OUT_W - N_TRIG - 1;

    for (genvar k = 0; k < N_TRIG; k++) begin : g_trig
        // Purpose: register one AND-combined trigger condition.
        always_ff @(posedge clk) begin
            if (!rst_n) trig_q[k] <= 1'b0;
            else        trig_q[k] <= (act_mask[k] != '0) && ((elem_q & act_mask[k]) == act_mask[k]);
        end
    end

    // Purpose: register the OR decision and the supervisor word together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= 1'b0;
            sup_q <= '0;
        end else begin
            dec_q <= |trig_q;
            sup_q <= {{PAD_W{1'b0}}, |trig_q, trig_q};
        end
    end
endmodule

// File: rtl/trig_decision_unit.sv
`timescale 1ns/1ps
// Module: top of the configurable trigger decision unit. Alignment, slot
// compare, trigger network; outputs follow the aligned data by three edges.
// Assumes fully synchronous inputs on clk.
module trig_decision_unit
    import tdu_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_WORDS*WORD_W-1:0]  in_words,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [DATA_W-1:0]          cfg_wdata,
    input  logic                       cfg_apply,
    output logic                       decision,
    output logic [OUT_W-1:0]           sup_word
);
    slot_t              act_slot [N_SLOT];
    logic [THR_W-1:0]   act_thr  [N_SLOT];
    logic [N_SLOT-1:0]  act_mask [N_TRIG];
    logic [DLY_W-1:0]   act_dly  [N_WORDS];
    logic [WORD_W-1:0]  aligned  [N_WORDS];
    logic [N_SLOT-1:0]  elem_q;
    logic [N_TRIG-1:0]  trig_q;

    tdu_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_apply(cfg_apply), .act_slot(act_slot),
        .act_thr(act_thr), .act_mask(act_mask), .act_dly(act_dly)
    );

    tdu_align u_align (
        .clk(clk), .rst_n(rst_n), .in_flat(in_words), .dly(act_dly), .aligned(aligned)
    );

    tdu_elem u_elem (
        .clk(clk), .rst_n(rst_n), .aligned(aligned), .act_slot(act_slot),
        .act_thr(act_thr), .elem_q(elem_q)
    );

    tdu_comb u_comb (
        .clk(clk), .rst_n(rst_n), .elem_q(elem_q), .act_mask(act_mask),
        .trig_q(trig_q), .dec_q(decision), .sup_q(sup_word)
    );
endmodule

// File: rtl/trig_decision_unit_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the decision unit, bound to the top.
module trig_decision_unit_chk
    import tdu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_apply,
    input slot_t              act_slot [N_SLOT],
    input logic [THR_W-1:0]   act_thr  [N_SLOT],
    input logic [N_SLOT-1:0]  act_mask [N_TRIG],
    input logic [N_SLOT-1:0]  elem_q,
    input logic [N_TRIG-1:0]  trig_q,
    input logic               decision,
    input logic [OUT_W-1:0]   sup_word
);
    for (genvar s = 0; s < N_SLOT; s++) begin : g_s
        assert_disabled_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (act_slot[s].op == OP_OFF) |=> !elem_q[s])
            else $error("disabled slot produced a hit");
        assert_thr_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_apply |=> $stable(act_thr[s]))
            else $error("threshold changed without apply");
    end

    for (genvar k = 0; k < N_TRIG; k++) begin : g_k
        assert_empty_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (act_mask[k] == '0) |=> !trig_q[k])
            else $error("empty mask fired");
        assert_mask_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_apply |=> $stable(act_mask[k]))
            else $error("mask changed without apply");
    end

    assert_dec_has_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        decision |-> (sup_word[N_TRIG-1:0] != '0))
        else $error("decision without trigger bit");

    assert_dec_follows_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q != '0) |=> decision)
        else $error("trigger did not raise decision");

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sup_word[OUT_W-1:N_TRIG+1] == '0)
        else $error("reserved bits set");
endmodule

bind trig_decision_unit trig_decision_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_apply(cfg_apply), .act_slot(act_slot),
    .act_thr(act_thr), .act_mask(act_mask), .elem_q(elem_q), .trig_q(trig_q),
    .decision(decision), .sup_word(sup_word)
);

// File: tb/trig_decision_unit_test.sv
`timescale 1ns/1ps
module trig_decision_unit_test;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [767:0]  in_words = '0;
    logic          cfg_we = 1'b0;
    logic [6:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          cfg_apply = 1'b0;
    logic          decision;
    logic [15:0]   sup_word;

    int    n_chk = 0;
    int    n_err = 0;
    int    skip = 2;
    string cur_req = "R1";

    always #2 clk = ~clk;

    trig_decision_unit uut (
        .clk(clk), .rst_n(rst_n), .in_words(in_words), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_apply(cfg_apply),
        .decision(decision), .sup_word(sup_word)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_hist [0:7][0:23];
    logic [31:0] al [0:23];
    logic [24:0] sh_slot [16], ac_slot [16];
    logic [15:0] sh_thr [16], ac_thr [16];
    logic [15:0] sh_msk [8], ac_msk [8];
    logic [2:0]  sh_dly [24], ac_dly [24];
    logic [15:0] pipe [0:2];
    logic [15:0] cur_exp;

    function automatic int mfield(input int s);
        logic [24:0] sl = ac_slot[s];
        logic [31:0] w = (sl[4:0] < 24) ? al[sl[4:0]] : 32'd0;
        return int'((w >> sl[9:5]) & {20'd0, sl[21:10]});
    endfunction

    function automatic bit slot_hit(input int s);
        logic [24:0] sl = ac_slot[s];
        int v = sl[24] ? mfield(s) + mfield((s + 1) % 16) : mfield(s);
        case (sl[23:22])
            2'b00: return v >  int'(ac_thr[s]);
            2'b01: return v <  int'(ac_thr[s]);
            2'b10: return v == int'(ac_thr[s]);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] model_out();
        logic [15:0] e;
        logic [7:0]  t;
        for (int s = 0; s < 16; s++) e[s] = slot_hit(s);
        for (int k = 0; k < 8; k++) t[k] = (ac_msk[k] != 0) && ((e & ac_msk[k]) == ac_msk[k]);
        return {7'd0, |t, t};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) for (int w = 0; w < 24; w++) m_hist[k][w] = '0;
            for (int s = 0; s < 16; s++) begin
                sh_slot[s] = 25'(3) << 22; ac_slot[s] = 25'(3) << 22;
                sh_thr[s] = '0; ac_thr[s] = '0;
            end
            for (int k = 0; k < 8; k++) begin sh_msk[k] = '0; ac_msk[k] = '0; end
            for (int w = 0; w < 24; w++) begin sh_dly[w] = '0; ac_dly[w] = '0; end
            for (int k = 0; k < 3; k++) pipe[k] = '0;
            cur_exp = '0;
            skip = 2;
        end else begin
            for (int k = 7; k > 0; k--) for (int w = 0; w < 24; w++) m_hist[k][w] = m_hist[k-1][w];
            for (int w = 0; w < 24; w++) m_hist[0][w] = in_words[w*32 +: 32];
            for (int w = 0; w < 24; w++) al[w] = m_hist[ac_dly[w]][w];
            cur_exp = pipe[2];
            pipe[2] = pipe[1];
            pipe[1] = pipe[0];
            pipe[0] = model_out();
            if (skip > 0) skip--;
            if (cfg_apply) begin
                ac_slot = sh_slot; ac_thr = sh_thr; ac_msk = sh_msk; ac_dly = sh_dly;
                skip = 4;
            end
            if (cfg_we) begin
                if (cfg_addr < 16) sh_slot[cfg_addr] = cfg_wdata[24:0];
                else if (cfg_addr < 32) sh_thr[cfg_addr-16] = cfg_wdata[15:0];
                else if (cfg_addr < 40) sh_msk[cfg_addr-32] = cfg_wdata[15:0];
                else if (cfg_addr >= 64 && cfg_addr < 88) sh_dly[cfg_addr-64] = cfg_wdata[2:0];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && skip == 0)
            chk(cur_req, {15'd0, decision, sup_word}, {15'd0, cur_exp[8], cur_exp});
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic apply();
        cfg_apply = 1'b1;
        cyc(1);
        cfg_apply = 1'b0;
    endtask

    function automatic logic [31:0] enc(input int idx, input int off, input int fm, input int op, input int sm);
        return (32'(sm) << 24) | (32'(op) << 22) | (32'(fm) << 10) | (32'(off) << 5) | 32'(idx);
    endfunction

    task automatic setw(input int w, input logic [31:0] v);
        in_words[w*32 +: 32] = v;
    endtask

    task automatic outs(input string req, input logic [15:0] exp);
        chk(req, {15'd0, decision, sup_word}, {15'd0, exp[8], exp});
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++; n_err++;
        $display("FAIL watchdog R10 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        cur_req = "R1";
        outs("R1 reset state", 16'h0000);

        // Slot setup: word 3, shift 4, 8-bit mask (R12)
        wr(0, enc(3, 4, 12'hFF, 0, 0));  wr(16, 32'h20);   // R2 greater
        wr(1, enc(3, 4, 12'hFF, 1, 0));  wr(17, 32'h10);   // R3 less
        wr(2, enc(3, 4, 12'hFF, 2, 0));  wr(18, 32'h20);   // R4 equal
        wr(3, enc(3, 4, 12'hFF, 0, 0));  wr(19, 32'h05);   // R7 window low
        wr(4, enc(3, 4, 12'hFF, 1, 0));  wr(20, 32'h30);   // R7 window high
        wr(5, enc(5, 0, 12'hFFF, 0, 1)); wr(21, 32'h1000); // R6 sum
        wr(6, enc(6, 0, 12'hFFF, 3, 0)); wr(22, 32'h0);    // R5 disabled
        wr(7, enc(30, 0, 12'hFFF, 0, 0)); wr(23, 32'h0);   // R12 out of range
        wr(32, 32'h01); wr(33, 32'h02); wr(34, 32'h04); wr(35, 32'h18);
        wr(36, 32'h20); wr(37, 32'h40); wr(38, 32'h80); wr(39, 32'h00);

        cur_req = "R11";
        setw(3, 32'h210);
        cyc(8);
        outs("R11 shadow writes without apply", 16'h0000);

        apply();
        cyc(8);
        cur_req = "R2";
        outs("R2 R7 greater and window", 16'h0109);

        setw(3, 32'h0F0);
        cyc(8);
        cur_req = "R3";
        outs("R3 less", 16'h010A);

        setw(3, 32'h200);
        cyc(8);
        cur_req = "R4";
        outs("R4 equal", 16'h010C);

        setw(3, 32'h400);
        cyc(8);
        cur_req = "R7";
        outs("R7 R8 window broken by high cut", 16'h0101);

        setw(3, 32'h0); setw(5, 32'h900); setw(6, 32'h800);
        cyc(8);
        cur_req = "R6";
        outs("R6 sum above threshold", 16'h0112);
        setw(6, 32'h6FF);
        cyc(8);
        outs("R6 sum at 0xFFF not above", 16'h0102);

        setw(6, 32'hFFF);
        cyc(8);
        cur_req = "R5";
        chk("R5 disabled slot trigger bit", {31'd0, sup_word[5]}, 32'd0);

        for (int w = 0; w < 24; w++) setw(w, 32'hFFFF_FFFF);
        cyc(8);
        cur_req = "R12";
        outs("R12 all-ones inputs, index 30 reads zero", 16'h0111);
        chk("R8 empty mask trigger bit", {31'd0, sup_word[7]}, 32'd0);

        cur_req = "R11";
        wr(32, 32'h0);
        cyc(8);
        outs("R11 mask write held in shadow", 16'h0111);
        apply();
        cyc(8);
        outs("R11 mask applied", 16'h0110);

        // Latency with word 3 delayed by 5 (R10)
        cur_req = "R10";
        wr(32, 32'h01);
        for (int k = 1; k < 8; k++) wr(32 + k, 32'h0);
        wr(64 + 3, 32'd5);
        for (int w = 0; w < 24; w++) setw(w, 32'h0);
        apply();
        cyc(12);
        outs("R10 idle before pulse", 16'h0000);
        setw(3, 32'h210);
        cyc(1);
        setw(3, 32'h0);
        cyc(7);
        outs("R10 one edge early", 16'h0000);
        cyc(1);
        outs("R10 decision on time", 16'h0101);
        cyc(1);
        outs("R10 one edge late", 16'h0000);

        // Zero delay: latency of three edges
        wr(64 + 3, 32'd0);
        apply();
        cyc(8);
        setw(3, 32'h210);
        cyc(1);
        setw(3, 32'h0);
        cyc(2);
        outs("R10 zero delay early", 16'h0000);
        cyc(1);
        outs("R10 zero delay on time", 16'h0101);

        cur_req = "R9";
        cyc(20);
        finish_run();
    end
endmodule